// File: doc/BRIEF.md
# Banked Stack Pointer Mode Controller

This block keeps the two banked stack pointers of a processor core, a main pointer and a process pointer. It also holds a two-bit control word and follows the core's execution state. The state is either Thread (ordinary code) or Handler (servicing an exception). Exception entry and exit strobes drive a nesting counter, and the core is in Handler state whenever that counter is nonzero. From the state and the control bits the block works out the current privilege and which bank is the active stack pointer.

Software and the surrounding core can reach the registers in three ways:
- a named write to the control word,
- a named write to either pointer bank,
- a write through the active-pointer port, which lands in whichever bank is selected in that cycle.

Privilege rules and the Handler-state rules decide which of these writes take effect. Every value stored into a bank is forced word-aligned.

Top module: `stack_bank_ctrl`

## Requirements
- R1: After reset the block is in Thread state (`in_handler`=0), `privileged`=1, `ctl_rdata`=0, and `active_sp` shows the main bank at its reset value.
- R2: While `in_handler`=1, `active_sp` is the main bank whatever the select bit holds.
- R3: While `in_handler`=1, `privileged`=1 whatever the unprivileged bit holds.
- R4: In Thread state, select bit 0 makes `active_sp` the main bank and select bit 1 makes it the process bank. A select change is visible from the cycle after the write.
- R5: A control write made in Handler state leaves the select bit unchanged and still updates the unprivileged bit.
- R6: Setting the unprivileged bit in Thread state clears `privileged` from the next cycle. While unprivileged, control writes and named process-bank writes are ignored.
- R7: Each entry strobe raises the nesting depth by one and each exit strobe lowers it by one. Entry and exit in the same cycle leave the depth unchanged. Thread state returns only when the depth reaches zero.
- R8: An exit strobe at depth zero, or an entry strobe at the maximum depth (2^DEPTH_W-1), is ignored and pulses `nest_err` high for exactly the following cycle.
- R9: A write on the active-pointer port changes only the bank selected in that cycle; the other bank keeps its value.
- R10: Every value stored into either bank has bits [1:0] forced to zero.
- R11: `ctl_rdata` bit 0 is the unprivileged flag, bit 1 is the select flag, and all higher bits read zero.
- R12: In a cycle where an accepted named write and an active-port write target the same bank, the named write's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_leave | input | 1 | Exception exit strobe |
| ctl_wr_en | input | 1 | Control word write request |
| ctl_wr_data | input | 2 | Control data: bit 0 unprivileged, bit 1 select |
| msp_wr_en | input | 1 | Named write to the main bank |
| psp_wr_en | input | 1 | Named write to the process bank (needs privilege) |
| sp_wr_data | input | SP_W | Data for named bank writes |
| act_wr_en | input | 1 | Write to whichever bank is active |
| act_wr_data | input | SP_W | Data for the active-pointer write |
| active_sp | output | SP_W | Currently active stack pointer |
| in_handler | output | 1 | 1 in Handler state, 0 in Thread state |
| privileged | output | 1 | Current privilege |
| ctl_rdata | output | CTL_W | Control word read-back |
| nest_err | output | 1 | One-cycle pulse after an ignored nesting strobe |

## Verification
The hardest situation to reach is a Handler-state control write, because the select bit must hold while the unprivileged bit changes. Handler state can only be entered through the entry strobe, and unprivileged Thread state through a control write, so the visible effect only shows once the nesting count unwinds back to zero. The stimulus first selects the process bank, then enters Handler state, writes the control word there, and nests further with a simultaneous entry/exit cycle. Only after unwinding every level does it expect an unprivileged Thread core running on the process bank. Saturation of the nesting counter is reached by a run of entry strobes one longer than the counter's capacity.

// File: rtl/stkctl_pkg.sv
package stkctl_pkg;

  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } exec_mode_e;

  typedef enum logic [1:0] {
    NEST_HOLD = 2'd0,
    NEST_UP   = 2'd1,
    NEST_DN   = 2'd2,
    NEST_BAD  = 2'd3
  } nest_op_e;

  typedef struct packed {
    logic sel_proc;
    logic unpriv;
  } ctl_bits_t;

  // Decide what a pair of nesting strobes does to the depth counter.
  function automatic nest_op_e nest_decide(input logic up, input logic dn,
                                           input logic at_zero, input logic at_max);
    nest_op_e op;
    if (up && dn)      op = NEST_HOLD;
    else if (up)       op = at_max  ? NEST_BAD : NEST_UP;
    else if (dn)       op = at_zero ? NEST_BAD : NEST_DN;
    else               op = NEST_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/stk_nest_tracker.sv
module stk_nest_tracker
  import stkctl_pkg::*;
#(
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enter_i,
  input  logic               leave_i,
  output logic [DEPTH_W-1:0] depth_o,
  output exec_mode_e         mode_o,
  output logic               bad_strobe_o,
  output logic               err_o
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

  logic [DEPTH_W-1:0] depth_q;
  logic               err_q;
  nest_op_e           op;

  always_comb begin
    op           = nest_decide(enter_i, leave_i, depth_q == '0, depth_q == DEPTH_MAX);
    bad_strobe_o = (op == NEST_BAD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (op == NEST_BAD);
      case (op)
        NEST_UP: depth_q <= depth_q + 1'b1;
        NEST_DN: depth_q <= depth_q - 1'b1;
        default: depth_q <= depth_q;
      endcase
    end
  end

  assign depth_o = depth_q;
  assign mode_o  = (depth_q != '0) ? MODE_HANDLER : MODE_THREAD;
  assign err_o   = err_q;
endmodule

// File: rtl/stk_ctl_bits.sv
module stk_ctl_bits
  import stkctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  ctl_bits_t  wr_data_i,
  input  logic       priv_now_i,
  input  exec_mode_e mode_i,
  output ctl_bits_t  ctl_o,
  output logic       take_unpriv_o,
  output logic       take_sel_o
);
  ctl_bits_t ctl_q;

  always_comb begin
    take_unpriv_o = wr_en_i && priv_now_i;
    take_sel_o    = wr_en_i && priv_now_i && (mode_i == MODE_THREAD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (take_unpriv_o) ctl_q.unpriv   <= wr_data_i.unpriv;
      if (take_sel_o)    ctl_q.sel_proc <= wr_data_i.sel_proc;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int              SP_W = 32,
  parameter logic [SP_W-1:0] INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            named_en_i,
  input  logic            named_ok_i,
  input  logic [SP_W-1:0] named_data_i,
  input  logic            port_en_i,
  input  logic            port_hit_i,
  input  logic [SP_W-1:0] port_data_i,
  output logic [SP_W-1:0] value_o,
  output logic            took_named_o,
  output logic            took_port_o
);
  function automatic logic [SP_W-1:0] word_align(input logic [SP_W-1:0] v);
    return {v[SP_W-1:2], 2'b00};
  endfunction

  logic [SP_W-1:0] val_q;

  always_comb begin
    took_named_o = named_en_i && named_ok_i;
    took_port_o  = port_en_i && port_hit_i && !took_named_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            val_q <= word_align(INIT);
    else if (took_named_o) val_q <= word_align(named_data_i);
    else if (took_port_o)  val_q <= word_align(port_data_i);
  end

  assign value_o = val_q;
endmodule

// File: rtl/stack_bank_ctrl.sv
module stack_bank_ctrl
  import stkctl_pkg::*;
#(
  parameter int              SP_W     = 32,
  parameter int              DEPTH_W  = 3,
  parameter int              CTL_W    = 32,
  parameter logic [SP_W-1:0] MSP_INIT = 32'h2000_0400,
  parameter logic [SP_W-1:0] PSP_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_enter,
  input  logic             exc_leave,
  input  logic             ctl_wr_en,
  input  logic [1:0]       ctl_wr_data,
  input  logic             msp_wr_en,
  input  logic             psp_wr_en,
  input  logic [SP_W-1:0]  sp_wr_data,
  input  logic             act_wr_en,
  input  logic [SP_W-1:0]  act_wr_data,
  output logic [SP_W-1:0]  active_sp,
  output logic             in_handler,
  output logic             privileged,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             nest_err
);
  localparam int N_BANK  = 2;
  localparam int BANK_M  = 0;
  localparam int BANK_P  = 1;
  localparam int CTL_PAD = CTL_W - 2;

  exec_mode_e         cur_mode;
  logic [DEPTH_W-1:0] nest_depth;
  logic               bad_strobe;
  ctl_bits_t          ctl_cur;
  logic               priv_now;
  logic               use_proc;
  logic               take_unpriv;
  logic               take_sel;

  logic [SP_W-1:0]   bank_val   [N_BANK];
  logic [N_BANK-1:0] bank_named;
  logic [N_BANK-1:0] bank_ok;
  logic [N_BANK-1:0] bank_hit;
  logic [N_BANK-1:0] took_named;
  logic [N_BANK-1:0] took_port;
  logic [SP_W-1:0]   msp_val;
  logic [SP_W-1:0]   psp_val;

  stk_nest_tracker #(.DEPTH_W(DEPTH_W)) u_nest (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_i     (exc_enter),
    .leave_i     (exc_leave),
    .depth_o     (nest_depth),
    .mode_o      (cur_mode),
    .bad_strobe_o(bad_strobe),
    .err_o       (nest_err)
  );

  always_comb begin
    priv_now = (cur_mode == MODE_HANDLER) || !ctl_cur.unpriv;
    use_proc = (cur_mode == MODE_THREAD) && ctl_cur.sel_proc;
  end

  stk_ctl_bits u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (ctl_wr_en),
    .wr_data_i    (ctl_bits_t'(ctl_wr_data)),
    .priv_now_i   (priv_now),
    .mode_i       (cur_mode),
    .ctl_o        (ctl_cur),
    .take_unpriv_o(take_unpriv),
    .take_sel_o   (take_sel)
  );

  always_comb begin
    bank_named[BANK_M] = msp_wr_en;
    bank_named[BANK_P] = psp_wr_en;
    bank_ok[BANK_M]    = 1'b1;
    bank_ok[BANK_P]    = priv_now;
    bank_hit[BANK_M]   = !use_proc;
    bank_hit[BANK_P]   = use_proc;
  end

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    stk_sp_reg #(
      .SP_W(SP_W),
      .INIT((g == BANK_M) ? MSP_INIT : PSP_INIT)
    ) u_sp (
      .clk         (clk),
      .rst_n       (rst_n),
      .named_en_i  (bank_named[g]),
      .named_ok_i  (bank_ok[g]),
      .named_data_i(sp_wr_data),
      .port_en_i   (act_wr_en),
      .port_hit_i  (bank_hit[g]),
      .port_data_i (act_wr_data),
      .value_o     (bank_val[g]),
      .took_named_o(took_named[g]),
      .took_port_o (took_port[g])
    );
  end

  assign msp_val    = bank_val[BANK_M];
  assign psp_val    = bank_val[BANK_P];
  assign active_sp  = use_proc ? psp_val : msp_val;
  assign in_handler = (cur_mode == MODE_HANDLER);
  assign privileged = priv_now;
  assign ctl_rdata  = {{CTL_PAD{1'b0}}, ctl_cur.sel_proc, ctl_cur.unpriv};
endmodule

// File: rtl/stack_bank_ctrl_chk.sv
module stack_bank_ctrl_chk #(
  parameter int SP_W    = 32,
  parameter int DEPTH_W = 3,
  parameter int CTL_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_enter,
  input logic               exc_leave,
  input logic               ctl_wr_en,
  input logic               in_handler,
  input logic               privileged,
  input logic [SP_W-1:0]    active_sp,
  input logic [SP_W-1:0]    msp_val,
  input logic [SP_W-1:0]    psp_val,
  input logic [CTL_W-1:0]   ctl_rdata,
  input logic [DEPTH_W-1:0] nest_depth,
  input logic               nest_err
);
  assert_handler_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> active_sp == msp_val);

  assert_handler_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> privileged);

  assert_thread_proc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_handler && ctl_rdata[1]) |-> active_sp == psp_val);

  assert_sel_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_handler && ctl_wr_en) |=> ctl_rdata[1] == $past(ctl_rdata[1]));

  assert_unpriv_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!privileged && ctl_wr_en) |=> $stable(ctl_rdata));

  assert_stay_handler_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_depth > 1) |=> in_handler);

  assert_exit_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_leave && !exc_enter && !in_handler) |=> nest_err);

  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msp_val[1:0] == 2'b00) && (psp_val[1:0] == 2'b00));

  assert_ctl_pad_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CTL_W-1:2] == '0);
endmodule

bind stack_bank_ctrl stack_bank_ctrl_chk #(
  .SP_W(SP_W), .DEPTH_W(DEPTH_W), .CTL_W(CTL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_enter (exc_enter),
  .exc_leave (exc_leave),
  .ctl_wr_en (ctl_wr_en),
  .in_handler(in_handler),
  .privileged(privileged),
  .active_sp (active_sp),
  .msp_val   (msp_val),
  .psp_val   (psp_val),
  .ctl_rdata (ctl_rdata),
  .nest_depth(nest_depth),
  .nest_err  (nest_err)
);

// File: tb/tb_stack_bank_ctrl.sv
`timescale 1ns/1ps
module tb_stack_bank_ctrl;
  localparam int          SP_W     = 32;
  localparam int          DEPTH_W  = 3;
  localparam int          CTL_W    = 32;
  localparam logic [31:0] MSP_INIT = 32'h2000_0400;
  localparam logic [31:0] PSP_INIT = 32'h0;
  localparam int          DMAX     = (1 << DEPTH_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             exc_enter = 0, exc_leave = 0, ctl_wr_en = 0;
  logic [1:0]       ctl_wr_data = '0;
  logic             msp_wr_en = 0, psp_wr_en = 0, act_wr_en = 0;
  logic [SP_W-1:0]  sp_wr_data = '0, act_wr_data = '0;
  logic [SP_W-1:0]  active_sp;
  logic             in_handler, privileged, nest_err;
  logic [CTL_W-1:0] ctl_rdata;

  always #2.5 clk = ~clk;

  stack_bank_ctrl #(
    .SP_W(SP_W), .DEPTH_W(DEPTH_W), .CTL_W(CTL_W),
    .MSP_INIT(MSP_INIT), .PSP_INIT(PSP_INIT)
  ) dut (.*);

  typedef struct {
    logic [31:0] sp;
    logic        hnd;
    logic        priv;
    logic [31:0] ctl;
    logic        err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;

  // reference state
  logic [31:0] m_msp, m_psp;
  int          m_depth;
  logic        m_np, m_sel;

  function automatic logic [31:0] algn(input logic [31:0] v);
    return v & 32'hFFFF_FFFC;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per cycle after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "active_sp",  active_sp,         e.sp);
      cmp(t, "in_handler", {31'b0, in_handler}, {31'b0, e.hnd});
      cmp(t, "privileged", {31'b0, privileged}, {31'b0, e.priv});
      cmp(t, "ctl_rdata",  ctl_rdata,         e.ctl);
      cmp(t, "nest_err",   {31'b0, nest_err},   {31'b0, e.err});
    end
  end

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input string tag, input logic en, input logic ex,
                      input logic cwe, input logic [1:0] cwd,
                      input logic mwe, input logic pwe, input logic [31:0] swd,
                      input logic awe, input logic [31:0] awd);
    logic hnd, priv, selp, err;
    exp_t e;
    @(negedge clk);
    exc_enter = en; exc_leave = ex; ctl_wr_en = cwe; ctl_wr_data = cwd;
    msp_wr_en = mwe; psp_wr_en = pwe; sp_wr_data = swd;
    act_wr_en = awe; act_wr_data = awd;
    hnd  = (m_depth != 0);
    priv = hnd || !m_np;
    selp = !hnd && m_sel;
    err  = 1'b0;
    // banks: accepted named write first, else active-port write
    if (mwe)                 m_msp = algn(swd);
    else if (awe && !selp)   m_msp = algn(awd);
    if (pwe && priv)         m_psp = algn(swd);
    else if (awe && selp)    m_psp = algn(awd);
    if (cwe && priv) begin
      m_np = cwd[0];
      if (!hnd) m_sel = cwd[1];
    end
    if (en && !ex) begin
      if (m_depth == DMAX) err = 1'b1; else m_depth++;
    end else if (ex && !en) begin
      if (m_depth == 0) err = 1'b1; else m_depth--;
    end
    e.hnd  = (m_depth != 0);
    e.priv = e.hnd || !m_np;
    e.sp   = (e.hnd || !m_sel) ? m_msp : m_psp;
    e.ctl  = {30'b0, m_sel, m_np};
    e.err  = err;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string t);            step(t,0,0,0,2'b00,0,0,0,0,0); endtask
  task automatic enter(input string t);           step(t,1,0,0,2'b00,0,0,0,0,0); endtask
  task automatic leave(input string t);           step(t,0,1,0,2'b00,0,0,0,0,0); endtask
  task automatic wctl(input string t, input logic [1:0] d);    step(t,0,0,1,d,0,0,0,0,0); endtask
  task automatic wmsp(input string t, input logic [31:0] d);   step(t,0,0,0,2'b00,1,0,d,0,0); endtask
  task automatic wpsp(input string t, input logic [31:0] d);   step(t,0,0,0,2'b00,0,1,d,0,0); endtask
  task automatic wact(input string t, input logic [31:0] d);   step(t,0,0,0,2'b00,0,0,0,1,d); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exc_enter = 0; exc_leave = 0; ctl_wr_en = 0; msp_wr_en = 0;
    psp_wr_en = 0; act_wr_en = 0;
    repeat (2) @(negedge clk);
    m_msp = algn(MSP_INIT); m_psp = algn(PSP_INIT);
    m_depth = 0; m_np = 1'b0; m_sel = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    idle("R1");
    wmsp("R10", 32'h2000_4003);
    wpsp("R10", 32'h1000_0FFF);
    wctl("R4",  2'b10);            // select process bank; readback R11
    idle("R11");
    wact("R9",  32'h1000_0AA5);    // lands in process bank only
    wctl("R4",  2'b00);            // back to main: must still be unchanged
    wact("R9",  32'h2000_3FF2);
    wctl("R4",  2'b10);
    enter("R2");                   // handler: main bank despite select
    wctl("R5",  2'b01);            // unpriv set, select must stay 1
    idle("R3");
    wact("R9",  32'h2000_3E01);    // handler writes the main bank
    enter("R7");
    enter("R7");
    step("R7", 1, 1, 0, 2'b00, 0, 0, 0, 0, 0);
    leave("R7");
    leave("R7");
    leave("R7");                   // depth zero: thread, unprivileged, process bank
    wctl("R6",  2'b00);            // ignored
    wpsp("R6",  32'h3333_3330);    // ignored
    leave("R8");                   // exit at zero
    idle("R8");
    do_reset();
    idle("R1");
    wctl("R6",  2'b01);
    idle("R6");
    enter("R3");
    leave("R3");
    do_reset();
    for (int i = 0; i < DMAX + 1; i++) enter("R8");
    idle("R8");
    for (int i = 0; i < DMAX; i++) leave("R7");
    step("R12", 0, 0, 0, 2'b00, 1, 0, 32'h2000_0808, 1, 32'h2000_0C0C);
    wctl("R12", 2'b10);
    step("R12", 0, 0, 0, 2'b00, 0, 1, 32'h1000_0100, 1, 32'h1000_0200);
    idle("R12");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule